// File: doc/BRIEF.md
# Grid Scan and Duty Timing Generator

This block drives the time multiplexing of a dot-matrix vacuum fluorescent display with up to 24 digit positions. It steps through the digit grids one at a time in ascending order, starting from the first grid. For each digit it opens a display window whose length sets the display contrast, and then closes it for a blank tail. The blank tail keeps one digit's segment pattern from showing on the next grid.

Timing is derived from the oscillator clock. A base unit of 8 clocks is grouped into sub-slots of 4 units, and a digit slot holds 16 sub-slots, which is 512 clocks. A 3-bit contrast code and a 4-bit digit-count code are sampled only at frame boundaries. The outputs are a one-hot grid enable vector, the index of the digit being shown (used to address the character memories), and a segment enable that is high only inside the display window.

Top module: `grid_scan_timer`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled, `grid_en`, `digit_idx` and `seg_en` are all zero. The first frame after reset uses 24 digits and contrast code 0, whatever the input codes are.
- R2: One sub-slot is 32 clocks (4 units of 8 clocks), and one digit slot is 16 sub-slots (512 clocks). Outputs are registered. The state reached p clocks after reset release appears on the outputs one clock later.
- R3: `digit_idx` counts up by one at each digit slot boundary, from 0 to the last digit of the frame, and then returns to 0.
- R4: With contrast code n, the grid bit of the current digit is high for the first 8+n sub-slots of its slot and low for the remaining 8-n. Code 0 gives 8/16 and code 7 gives 15/16.
- R5: `seg_en` is high exactly when a grid bit is high.
- R6: Digit-count code 0 scans 24 digits. Code k (1 to 15) scans k+8 digits. `grid_en` bit i belongs to digit index i.
- R7: Changes to `duty_code` or `digit_code` take effect only at the start of the next frame. A change in the middle of a frame has no effect on that frame.
- R8: At most one bit of `grid_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_code | input | 3 | Contrast code n, on-window of (8+n)/16 |
| digit_code | input | 4 | Digit-count code (0 selects 24, k selects k+8) |
| grid_en | output | 24 | One-hot grid enables, bit i for digit i |
| digit_idx | output | 5 | Index of the digit being displayed |
| seg_en | output | 1 | Segment enable, high inside the display window |

## Verification
The scoreboard samples the first, middle and last clock of every sub-slot. A window that is one clock late or early, or one sub-slot too long, therefore shows up as a wrong grid or `seg_en` value at a sub-slot edge. The codes are changed in the middle of a frame. A design that applies them at once would shorten that frame or jump the index, where a correct design finishes the frame with the old setting. The digit-count codes are run at their extremes (0 for 24 digits, 1 for 9, 15 for 23), so an off-by-one in the code decode would wrap at the wrong digit. The first frame after a reset with nonzero codes applied must still use 24 digits and 8/16.

// File: rtl/gst_pkg.sv
package gst_pkg;

    localparam int MAX_DIGITS   = 24;
    localparam int DIG_W        = $clog2(MAX_DIGITS);
    localparam int SUBSLOTS     = 16;
    localparam int SUB_W        = $clog2(SUBSLOTS);
    localparam int ON_W         = SUB_W + 1;
    localparam int DUTY_W       = 3;
    localparam int CODE_W       = 4;
    localparam int DUTY_BASE    = 8;
    localparam int COUNT_OFFSET = 8;

    typedef logic [DIG_W-1:0]  dig_t;
    typedef logic [SUB_W-1:0]  sub_t;
    typedef logic [ON_W-1:0]   on_t;

    // active scan configuration, held for a whole frame
    typedef struct packed {
        dig_t last_dig;   // index of the final digit of the frame
        on_t  on_subs;    // number of lit sub-slots per digit
    } scan_cfg_t;

    // registered output bundle
    typedef struct packed {
        logic [MAX_DIGITS-1:0] grid;
        dig_t                  idx;
        logic                  seg;
    } scan_out_t;

    function automatic dig_t decode_last(input logic [CODE_W-1:0] code);
        dig_t r;
        if (code == '0)
            r = dig_t'(MAX_DIGITS - 1);
        else
            r = dig_t'(int'(code) + COUNT_OFFSET - 1);
        return r;
    endfunction

    function automatic on_t decode_on(input logic [DUTY_W-1:0] duty);
        return on_t'(DUTY_BASE + int'(duty));
    endfunction

    function automatic scan_cfg_t decode_cfg(input logic [DUTY_W-1:0] duty,
                                             input logic [CODE_W-1:0] code);
        scan_cfg_t c;
        c.last_dig = decode_last(code);
        c.on_subs  = decode_on(duty);
        return c;
    endfunction

endpackage

// File: rtl/gst_tick_gen.sv
module gst_tick_gen #(
    parameter int CLKS_PER_T = 8,
    parameter int T_PER_SUB  = 4
) (
    input  logic clk,
    input  logic rst,
    output logic sub_tick
);
    localparam int CLKS_PER_SUB = CLKS_PER_T * T_PER_SUB;
    localparam int PRE_W        = (CLKS_PER_SUB > 1) ? $clog2(CLKS_PER_SUB) : 1;

    generate
        if (CLKS_PER_SUB == 1) begin : g_every_clock
            assign sub_tick = 1'b1;
        end else begin : g_divider
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst)
                    pre_q <= '0;
                else if (pre_q == PRE_W'(CLKS_PER_SUB - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end
            assign sub_tick = (pre_q == PRE_W'(CLKS_PER_SUB - 1));
        end
    endgenerate

endmodule

// File: rtl/gst_scan_seq.sv
module gst_scan_seq
    import gst_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sub_tick,
    input  logic [DUTY_W-1:0]   duty_code,
    input  logic [CODE_W-1:0]   digit_code,
    output sub_t                sub_q,
    output dig_t                dig_q,
    output scan_cfg_t           cfg_q,
    output logic                frame_wrap
);
    logic sub_last;
    logic dig_last;

    assign sub_last   = (sub_q == sub_t'(SUBSLOTS - 1));
    assign dig_last   = (dig_q == cfg_q.last_dig);
    assign frame_wrap = sub_tick && sub_last && dig_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            dig_q <= '0;
            cfg_q <= decode_cfg('0, '0);
        end else if (sub_tick) begin
            sub_q <= sub_last ? '0 : sub_q + 1'b1;
            if (sub_last)
                dig_q <= dig_last ? '0 : dig_q + 1'b1;
            if (frame_wrap)
                cfg_q <= decode_cfg(duty_code, digit_code);
        end
    end

    // R7: the configuration is frozen between frame boundaries
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !frame_wrap |=> $stable(cfg_q));

    // R2: sub-slot counter only advances on prescaler ticks
    a_r2_sub_on_tick: assert property (@(posedge clk) disable iff (rst)
        !sub_tick |=> $stable(sub_q));

    // R6: digit index never runs past the frame's last digit
    a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
        dig_q <= cfg_q.last_dig);

endmodule

// File: rtl/gst_window_out.sv
module gst_window_out
    import gst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sub_t       sub_q,
    input  dig_t       dig_q,
    input  scan_cfg_t  cfg_q,
    output scan_out_t  out_q
);
    logic                  on_now;
    logic [MAX_DIGITS-1:0] grid_d;

    assign on_now = (on_t'(sub_q) < cfg_q.on_subs);

    for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_grid
        assign grid_d[g] = on_now && (dig_q == dig_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.grid <= grid_d;
            out_q.idx  <= dig_q;
            out_q.seg  <= on_now;
        end
    end

    // R8: never two grids at once
    a_r8_single_grid: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_q.grid));

    // R5: segments follow the lit grid
    a_r5_seg_tracks_grid: assert property (@(posedge clk) disable iff (rst)
        out_q.seg == (out_q.grid != '0));

    // R1: the cycle after reset shows quiet outputs
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_q == '0));

    // R3: the index only steps up by one or returns to zero
    a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
        (out_q.idx != $past(out_q.idx)) |->
            ((out_q.idx == $past(out_q.idx) + 1'b1) || (out_q.idx == '0)));

endmodule

// File: rtl/grid_scan_timer.sv
module grid_scan_timer
    import gst_pkg::*;
#(
    parameter int CLKS_PER_T = 8,
    parameter int T_PER_SUB  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            duty_code,
    input  logic [3:0]            digit_code,
    output logic [23:0]           grid_en,
    output logic [4:0]            digit_idx,
    output logic                  seg_en
);
    logic      sub_tick;
    sub_t      sub_q;
    dig_t      dig_q;
    scan_cfg_t cfg_q;
    logic      frame_wrap;
    scan_out_t out_q;

    gst_tick_gen #(
        .CLKS_PER_T (CLKS_PER_T),
        .T_PER_SUB  (T_PER_SUB)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .sub_tick (sub_tick)
    );

    gst_scan_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .sub_tick   (sub_tick),
        .duty_code  (duty_code),
        .digit_code (digit_code),
        .sub_q      (sub_q),
        .dig_q      (dig_q),
        .cfg_q      (cfg_q),
        .frame_wrap (frame_wrap)
    );

    gst_window_out u_out (
        .clk   (clk),
        .rst   (rst),
        .sub_q (sub_q),
        .dig_q (dig_q),
        .cfg_q (cfg_q),
        .out_q (out_q)
    );

    assign grid_en   = out_q.grid;
    assign digit_idx = out_q.idx;
    assign seg_en    = out_q.seg;

endmodule

// File: tb/grid_scan_timer_tb.sv
module grid_scan_timer_tb;

    typedef struct packed {
        logic [23:0] grid;
        logic [4:0]  idx;
        logic        seg;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  duty_code = 3'd5;
    logic [3:0]  digit_code = 4'd3;
    logic [23:0] grid_en;
    logic [4:0]  digit_idx;
    logic        seg_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    exp_t exp_q[$];

    // reference state, built from the requirements
    int m_pre = 0, m_sub = 0, m_dig = 0, m_ndig = 24, m_on = 8;

    always #5 clk = ~clk;

    grid_scan_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .duty_code  (duty_code),
        .digit_code (digit_code),
        .grid_en    (grid_en),
        .digit_idx  (digit_idx),
        .seg_en     (seg_en)
    );

    // model: expected output after this edge comes from the state before it
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            m_pre = 0; m_sub = 0; m_dig = 0; m_ndig = 24; m_on = 8;
        end else begin
            e.idx  = 5'(m_dig);
            e.seg  = (m_sub < m_on);
            e.grid = e.seg ? (24'd1 << m_dig) : 24'd0;
            if (m_pre == 0 || m_pre == 16 || m_pre == 31)
                exp_q.push_back(e);
            m_pre++;
            if (m_pre == 32) begin
                m_pre = 0;
                m_sub++;
                if (m_sub == 16) begin
                    m_sub = 0;
                    m_dig++;
                    if (m_dig == m_ndig) begin
                        m_dig  = 0;
                        m_ndig = (digit_code == 4'd0) ? 24 : int'(digit_code) + 8;
                        m_on   = 8 + int'(duty_code);
                    end
                end
            end
        end
    end

    // monitor: pop expected items and compare
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (grid_en !== e.grid) begin
                n_bad++;
                $display("FAIL R2/R4/R6 grid_en: got %h expected %h", grid_en, e.grid);
            end
            n_chk++;
            if (digit_idx !== e.idx) begin
                n_bad++;
                $display("FAIL R3/R7 digit_idx: got %0d expected %0d", digit_idx, e.idx);
            end
            n_chk++;
            if (seg_en !== e.seg) begin
                n_bad++;
                $display("FAIL R5 seg_en: got %0b expected %0b", seg_en, e.seg);
            end
            n_chk++;
            if ($countones(grid_en) > 1) begin
                n_bad++;
                $display("FAIL R8 onehot: got %h expected at most one bit", grid_en);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_quiet(input int n);
        repeat (n) begin
            @(negedge clk);
            n_chk++;
            if (grid_en !== 24'd0 || digit_idx !== 5'd0 || seg_en !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 reset outputs: got %h/%0d/%0b expected 0/0/0",
                         grid_en, digit_idx, seg_en);
            end
        end
    endtask

    initial begin
        // R1: reset with nonzero codes applied
        rst = 1'b1;
        check_quiet(4);
        rst = 1'b0;
        // R1: default 24 digits, 8/16 for the whole first frame
        run(24 * 512);
        // R6/R4: code 3 gives 11 digits, duty 13/16; R7: change mid-frame
        run(2000);
        duty_code  = 3'd7;
        digit_code = 4'd1;
        run(11 * 512 - 2000);
        // 9 digits at 15/16, two frames
        run(2 * 9 * 512 - 1000);
        duty_code  = 3'd2;
        digit_code = 4'd15;
        run(1000);
        // 23 digits at 10/16
        run(23 * 512 + 700);
        duty_code  = 3'd7;
        digit_code = 4'd0;
        run(23 * 512 - 700);
        // 24 digits at 15/16
        run(24 * 512);
        // mid-run reset, R1
        duty_code  = 3'd0;
        digit_code = 4'd8;
        rst = 1'b1;
        check_quiet(3);
        rst = 1'b0;
        run(24 * 512 + 16 * 512 + 40);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule